// File: doc/BRIEF.md
# Paired Stack Pointer Interrupt Gate

This block keeps the two stack pointers of a small 4-bit processor core. One pointer addresses the stack that holds 16-bit words, such as return addresses. The other addresses the stack that holds 4-bit words, such as the saved flag register. The core's decoder drives the block with software writes to either pointer and with a stack operation code for calls, returns and returns from interrupt. The block updates both pointers itself when it accepts an interrupt.

Interrupt acceptance stays closed until software has written both pointers. The gate opens only when both writes have happened, counted from reset or from the last rewrite. While the gate is closed, every request is refused, including the non-maskable one.

Interrupt requests follow valid/ready rules. `nmi_req` and `irq_req` are valids. The requester holds them, and keeps `irq_idx` stable, until a cycle in which `irq_take` is high. `irq_take` is the ready, and it never rises while the gate is closed. It also stays low in any cycle that carries a pointer write or a stack operation. A request that is refused costs nothing and may be kept up.

`pc_ld` tells the core to load `pc_ld_addr` into its program counter. It does this for the start address after reset and for the vector of an accepted interrupt. All other pins are plain control and status.

Top module: `sp_pair_gate`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `sp16`, `sp4`, `ie_flag` and `ext_flag` read 0, `irq_take` is 0, and `pc_ld` is 1 with `pc_ld_addr` = 0x0110. In later cycles `pc_ld` equals `irq_take`.
- R2: After reset, `irq_take` stays 0 for both request kinds until both `sp16_wr` and `sp4_wr` have each been seen in some cycle.
- R3: With the gate open, a write to only one pointer closes it again. It stays closed until the other pointer is written. Further writes to the first pointer do not reopen it.
- R4: `stk_op` = 2'b01 (call) lowers `sp16` by 4, and `stk_op` = 2'b10 (return) raises it by 4. The new value is visible in the next cycle.
- R5: An accepted interrupt lowers `sp16` by 4 and `sp4` by 1. `stk_op` = 2'b11 (return from interrupt) raises `sp16` by 4 and `sp4` by 1.
- R6: `sp16` is 10 bits and wraps modulo 1024. `sp4` is 8 bits and wraps modulo 256. A call at 0x000 gives 0x3FC, and an entry at `sp4` = 0x00 gives 0xFF.
- R7: An accepted non-maskable request yields vector 0x0100. It wins over a maskable request in the same cycle.
- R8: A maskable request is accepted only while `ie_flag` is 1. Its vector is 0x0104 + 2 × `irq_idx`.
- R9: `ie_set` sets `ie_flag` and `ie_clr` clears it. An accepted interrupt clears it, and the clear wins over an `ie_set` in the same cycle.
- R10: No interrupt is accepted in a cycle with a pointer write or a non-zero `stk_op`. A request held into the next free cycle is accepted there.
- R11: `ext_set` sets `ext_flag` and `ext_clr` clears it. The clear wins when both are high.
- R12: A pointer write in the same cycle as a stack operation on that pointer wins: the pointer takes the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sp16_wr | input | 1 | Software write to the 16-bit-word stack pointer |
| sp16_wdata | input | 10 | Value for that write |
| sp4_wr | input | 1 | Software write to the 4-bit-word stack pointer |
| sp4_wdata | input | 8 | Value for that write |
| stk_op | input | 2 | 00 none, 01 call, 10 return, 11 return from interrupt |
| nmi_req | input | 1 | Non-maskable request (valid) |
| irq_req | input | 1 | Maskable request (valid) |
| irq_idx | input | 4 | Maskable request number |
| ie_set | input | 1 | Set interrupt-enable flag |
| ie_clr | input | 1 | Clear interrupt-enable flag |
| ext_set | input | 1 | Set extension flag |
| ext_clr | input | 1 | Clear extension flag |
| sp16 | output | 10 | 16-bit-word stack pointer |
| sp4 | output | 8 | 4-bit-word stack pointer |
| ie_flag | output | 1 | Interrupt-enable flag |
| ext_flag | output | 1 | Extension flag |
| irq_take | output | 1 | Interrupt accepted this cycle (ready) |
| pc_ld | output | 1 | Program counter load strobe |
| pc_ld_addr | output | 16 | Address to load |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is the write that completes the pointer pair and a held request. The bench keeps `nmi_req` high across that write. It expects no acceptance in the write cycle, since that cycle is busy and the gate is still closed, and it expects acceptance in the very next cycle.

The second pair is a held maskable request and a call. The bench raises both together. It expects `irq_take` low and `sp16` lowered only by the call, and then an acceptance one cycle later with the vector for the held index.

It also drives a non-maskable and a maskable request together with `ie_set` in the same cycle. It then checks the vector and confirms that `ie_flag` comes back 0.

// File: rtl/spg_pkg.sv
package spg_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_CALL = 2'b01,
    OP_RET  = 2'b10,
    OP_RETI = 2'b11
  } stk_op_e;
endpackage

// File: rtl/spg_ptr.sv
// One cyclic stack pointer: load, pre-decrement push, post-increment pop.
module spg_ptr #(
  parameter int W    = 10,
  parameter int STEP = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr,
  input  logic [W-1:0] wr_data,
  input  logic         dec,
  input  logic         inc,
  output logic [W-1:0] sp
);
  localparam logic [W-1:0] STEP_V = W'(STEP);

  logic [W-1:0] sp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   sp_q <= '0;
    else if (wr)  sp_q <= wr_data;
    else if (dec) sp_q <= sp_q - STEP_V;
    else if (inc) sp_q <= sp_q + STEP_V;
  end

  assign sp = sp_q;

  // R12
  wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> sp == $past(wr_data));

  // R6
  dec_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !wr && !inc) |=> sp == W'($past(sp) + (~STEP_V) + 1'b1));
endmodule

// File: rtl/spg_pair_gate.sv
// Tracks which pointers were written since reset or the last single rewrite.
module spg_pair_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic wr16,
  input  logic wr4,
  output logic open
);
  logic got16_q, got4_q;
  logic both;

  assign both = got16_q & got4_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      got16_q <= 1'b0;
      got4_q  <= 1'b0;
    end else if (both) begin
      if (wr16 && !wr4) got4_q  <= 1'b0;
      if (wr4 && !wr16) got16_q <= 1'b0;
    end else begin
      got16_q <= got16_q | wr16;
      got4_q  <= got4_q | wr4;
    end
  end

  assign open = both;

  // R2
  open_needs_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(open) |-> $past(wr16 || wr4));

  // R3
  rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (open && (wr16 != wr4)) |=> !open);
endmodule

// File: rtl/spg_irq_arb.sv
// Acceptance, priority, vector, flags and program-counter load selection.
module spg_irq_arb #(
  parameter int          IDX_W    = 4,
  parameter int          PC_W     = 16,
  parameter logic [15:0] BOOT_PC  = 16'h0110,
  parameter logic [15:0] NMI_VEC  = 16'h0100,
  parameter logic [15:0] IRQ_BASE = 16'h0104
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_open,
  input  logic             busy,
  input  logic             nmi_req,
  input  logic             irq_req,
  input  logic [IDX_W-1:0] irq_idx,
  input  logic             ie_set,
  input  logic             ie_clr,
  input  logic             ext_set,
  input  logic             ext_clr,
  output logic             take,
  output logic             ie_flag,
  output logic             ext_flag,
  output logic             pc_ld,
  output logic [PC_W-1:0]  pc_ld_addr
);
  localparam int PAD = PC_W - IDX_W - 1;

  logic            ie_q, ext_q, boot_q;
  logic            free, nmi_win, irq_win;
  logic [PC_W-1:0] vec;

  assign free    = gate_open & ~busy;
  assign nmi_win = free & nmi_req;
  assign irq_win = free & ~nmi_req & irq_req & ie_q;
  assign take    = nmi_win | irq_win;

  always_comb begin
    if (nmi_req) vec = PC_W'(NMI_VEC);
    else         vec = PC_W'(IRQ_BASE) + {{PAD{1'b0}}, irq_idx, 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      ext_q  <= 1'b0;
      boot_q <= 1'b1;
    end else begin
      boot_q <= 1'b0;
      if (take || ie_clr) ie_q <= 1'b0;
      else if (ie_set)    ie_q <= 1'b1;
      if (ext_clr)        ext_q <= 1'b0;
      else if (ext_set)   ext_q <= 1'b1;
    end
  end

  assign ie_flag    = ie_q;
  assign ext_flag   = ext_q;
  assign pc_ld      = boot_q | take;
  assign pc_ld_addr = boot_q ? PC_W'(BOOT_PC) : vec;

  // R9
  take_clears_ie_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> !ie_flag);

  // R7
  nmi_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && nmi_req) |-> pc_ld_addr == PC_W'(NMI_VEC));

  // R8
  masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ie_flag && !nmi_req) |-> !take);

  // R10
  busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !take);
endmodule

// File: rtl/sp_pair_gate.sv
module sp_pair_gate #(
  parameter int          SP16_W     = 10,
  parameter int          SP4_W      = 8,
  parameter int          IDX_W      = 4,
  parameter int          PC_W       = 16,
  parameter int          CALL_WORDS = 4,
  parameter int          FLAG_WORDS = 1,
  parameter logic [15:0] BOOT_PC    = 16'h0110,
  parameter logic [15:0] NMI_VEC    = 16'h0100,
  parameter logic [15:0] IRQ_BASE   = 16'h0104
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sp16_wr,
  input  logic [SP16_W-1:0] sp16_wdata,
  input  logic              sp4_wr,
  input  logic [SP4_W-1:0]  sp4_wdata,
  input  logic [1:0]        stk_op,
  input  logic              nmi_req,
  input  logic              irq_req,
  input  logic [IDX_W-1:0]  irq_idx,
  input  logic              ie_set,
  input  logic              ie_clr,
  input  logic              ext_set,
  input  logic              ext_clr,
  output logic [SP16_W-1:0] sp16,
  output logic [SP4_W-1:0]  sp4,
  output logic              ie_flag,
  output logic              ext_flag,
  output logic              irq_take,
  output logic              pc_ld,
  output logic [PC_W-1:0]   pc_ld_addr
);
  import spg_pkg::*;

  stk_op_e op;
  logic    busy, gate_open, take;
  logic    dec16, inc16, dec4, inc4;

  assign op    = stk_op_e'(stk_op);
  assign busy  = sp16_wr | sp4_wr | (op != OP_NONE);
  assign dec16 = (op == OP_CALL) | take;
  assign inc16 = (op == OP_RET) | (op == OP_RETI);
  assign dec4  = take;
  assign inc4  = (op == OP_RETI);

  spg_ptr #(.W(SP16_W), .STEP(CALL_WORDS)) i_ptr16 (
    .clk(clk), .rst_n(rst_n), .wr(sp16_wr), .wr_data(sp16_wdata),
    .dec(dec16), .inc(inc16), .sp(sp16)
  );

  spg_ptr #(.W(SP4_W), .STEP(FLAG_WORDS)) i_ptr4 (
    .clk(clk), .rst_n(rst_n), .wr(sp4_wr), .wr_data(sp4_wdata),
    .dec(dec4), .inc(inc4), .sp(sp4)
  );

  spg_pair_gate i_gate (
    .clk(clk), .rst_n(rst_n), .wr16(sp16_wr), .wr4(sp4_wr), .open(gate_open)
  );

  spg_irq_arb #(
    .IDX_W(IDX_W), .PC_W(PC_W), .BOOT_PC(BOOT_PC),
    .NMI_VEC(NMI_VEC), .IRQ_BASE(IRQ_BASE)
  ) i_arb (
    .clk(clk), .rst_n(rst_n), .gate_open(gate_open), .busy(busy),
    .nmi_req(nmi_req), .irq_req(irq_req), .irq_idx(irq_idx),
    .ie_set(ie_set), .ie_clr(ie_clr), .ext_set(ext_set), .ext_clr(ext_clr),
    .take(take), .ie_flag(ie_flag), .ext_flag(ext_flag),
    .pc_ld(pc_ld), .pc_ld_addr(pc_ld_addr)
  );

  assign irq_take = take;

  // R5
  entry_sp4_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_take |=> sp4 == SP4_W'($past(sp4) - SP4_W'(FLAG_WORDS)));
endmodule

// File: tb/test_sp_pair_gate.sv
`timescale 1ns/1ps
module test_sp_pair_gate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sp16_wr = 0, sp4_wr = 0;
  logic [9:0]  sp16_wdata = '0;
  logic [7:0]  sp4_wdata = '0;
  logic [1:0]  stk_op = 2'b00;
  logic        nmi_req = 0, irq_req = 0;
  logic [3:0]  irq_idx = '0;
  logic        ie_set = 0, ie_clr = 0, ext_set = 0, ext_clr = 0;
  logic [9:0]  sp16;
  logic [7:0]  sp4;
  logic        ie_flag, ext_flag, irq_take, pc_ld;
  logic [15:0] pc_ld_addr;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    string       tag;
    logic [9:0]  e16;
    logic [7:0]  e4;
    logic        eie, eext, etake, epcld;
    logic [15:0] eaddr;
  } exp_t;

  exp_t q[$];

  always #4 clk = ~clk;

  sp_pair_gate i_sp_pair_gate (
    .clk(clk), .rst_n(rst_n), .sp16_wr(sp16_wr), .sp16_wdata(sp16_wdata),
    .sp4_wr(sp4_wr), .sp4_wdata(sp4_wdata), .stk_op(stk_op),
    .nmi_req(nmi_req), .irq_req(irq_req), .irq_idx(irq_idx),
    .ie_set(ie_set), .ie_clr(ie_clr), .ext_set(ext_set), .ext_clr(ext_clr),
    .sp16(sp16), .sp4(sp4), .ie_flag(ie_flag), .ext_flag(ext_flag),
    .irq_take(irq_take), .pc_ld(pc_ld), .pc_ld_addr(pc_ld_addr)
  );

  task automatic cmp(string tag, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Monitor: pops one expectation per cycle, away from the active edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      cmp(e.tag, "sp16", 16'(sp16), 16'(e.e16));
      cmp(e.tag, "sp4", 16'(sp4), 16'(e.e4));
      cmp(e.tag, "ie_flag", 16'(ie_flag), 16'(e.eie));
      cmp(e.tag, "ext_flag", 16'(ext_flag), 16'(e.eext));
      cmp(e.tag, "irq_take", 16'(irq_take), 16'(e.etake));
      cmp(e.tag, "pc_ld", 16'(pc_ld), 16'(e.epcld));
      if (e.epcld) cmp(e.tag, "pc_ld_addr", pc_ld_addr, e.eaddr);
    end
  end

  // Driver: inputs already set by the caller; expectation queued; idle after the edge
  task automatic step(string tag, logic [9:0] e16, logic [7:0] e4, logic eie,
                      logic eext, logic etake, logic epcld, logic [15:0] eaddr);
    exp_t e;
    e.tag = tag; e.e16 = e16; e.e4 = e4; e.eie = eie; e.eext = eext;
    e.etake = etake; e.epcld = epcld; e.eaddr = eaddr;
    q.push_back(e);
    @(posedge clk);
    #2;
    sp16_wr = 0; sp4_wr = 0; stk_op = 2'b00; nmi_req = 0; irq_req = 0;
    irq_idx = '0; ie_set = 0; ie_clr = 0; ext_set = 0; ext_clr = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    #2;
    step("R1 in reset",      10'h000, 8'h00, 0, 0, 0, 1, 16'h0110);
    rst_n = 1;
    step("R1 release",       10'h000, 8'h00, 0, 0, 0, 1, 16'h0110);
    nmi_req = 1;
    step("R2 nmi no writes", 10'h000, 8'h00, 0, 0, 0, 0, 16'h0);
    nmi_req = 1; sp16_wr = 1; sp16_wdata = 10'h100;
    step("R2 wr16",          10'h000, 8'h00, 0, 0, 0, 0, 16'h0);
    nmi_req = 1;
    step("R2 only16",        10'h100, 8'h00, 0, 0, 0, 0, 16'h0);
    nmi_req = 1; sp4_wr = 1; sp4_wdata = 8'h10;
    step("R10 wr4 busy",     10'h100, 8'h00, 0, 0, 0, 0, 16'h0);
    nmi_req = 1;
    step("R7 nmi take",      10'h100, 8'h10, 0, 0, 1, 1, 16'h0100);
    step("R5 entry",         10'h0FC, 8'h0F, 0, 0, 0, 0, 16'h0);
    stk_op = 2'b11;
    step("R5 reti",          10'h0FC, 8'h0F, 0, 0, 0, 0, 16'h0);
    step("R5 after reti",    10'h100, 8'h10, 0, 0, 0, 0, 16'h0);
    ie_set = 1;
    step("R9 ie_set",        10'h100, 8'h10, 0, 0, 0, 0, 16'h0);
    irq_req = 1; irq_idx = 4'd3;
    step("R8 irq idx3",      10'h100, 8'h10, 1, 0, 1, 1, 16'h010A);
    step("R9 ie cleared",    10'h0FC, 8'h0F, 0, 0, 0, 0, 16'h0);
    irq_req = 1; irq_idx = 4'd5;
    step("R8 masked",        10'h0FC, 8'h0F, 0, 0, 0, 0, 16'h0);
    ie_set = 1;
    step("R9 ie_set again",  10'h0FC, 8'h0F, 0, 0, 0, 0, 16'h0);
    nmi_req = 1; irq_req = 1; irq_idx = 4'd2; ie_set = 1;
    step("R7 priority",      10'h0FC, 8'h0F, 1, 0, 1, 1, 16'h0100);
    step("R9 clear wins",    10'h0F8, 8'h0E, 0, 0, 0, 0, 16'h0);
    stk_op = 2'b01;
    step("R4 call",          10'h0F8, 8'h0E, 0, 0, 0, 0, 16'h0);
    stk_op = 2'b10;
    step("R4 ret",           10'h0F4, 8'h0E, 0, 0, 0, 0, 16'h0);
    sp16_wr = 1; sp16_wdata = 10'h000;
    step("R4 after ret",     10'h0F8, 8'h0E, 0, 0, 0, 0, 16'h0);
    stk_op = 2'b01;
    step("R6 call at zero",  10'h000, 8'h0E, 0, 0, 0, 0, 16'h0);
    nmi_req = 1;
    step("R3 rearmed",       10'h3FC, 8'h0E, 0, 0, 0, 0, 16'h0);
    nmi_req = 1; sp4_wr = 1; sp4_wdata = 8'h00;
    step("R3 wr4 busy",      10'h3FC, 8'h0E, 0, 0, 0, 0, 16'h0);
    nmi_req = 1;
    step("R3 reopened",      10'h3FC, 8'h00, 0, 0, 1, 1, 16'h0100);
    step("R6 wrap down",     10'h3F8, 8'hFF, 0, 0, 0, 0, 16'h0);
    stk_op = 2'b11;
    step("R6 reti",          10'h3F8, 8'hFF, 0, 0, 0, 0, 16'h0);
    sp16_wr = 1; sp16_wdata = 10'h200; stk_op = 2'b01;
    step("R6 wrap up",       10'h3FC, 8'h00, 0, 0, 0, 0, 16'h0);
    sp16_wr = 1; sp16_wdata = 10'h210;
    step("R12 write wins",   10'h200, 8'h00, 0, 0, 0, 0, 16'h0);
    nmi_req = 1;
    step("R3 same ptr twice", 10'h210, 8'h00, 0, 0, 0, 0, 16'h0);
    sp4_wr = 1; sp4_wdata = 8'h40;
    step("R3 wr4",           10'h210, 8'h00, 0, 0, 0, 0, 16'h0);
    nmi_req = 1;
    step("R3 open again",    10'h210, 8'h40, 0, 0, 1, 1, 16'h0100);
    ext_set = 1;
    step("R11 ext_set",      10'h20C, 8'h3F, 0, 0, 0, 0, 16'h0);
    ext_set = 1; ext_clr = 1;
    step("R11 ext set",      10'h20C, 8'h3F, 0, 1, 0, 0, 16'h0);
    ie_set = 1;
    step("R11 clear wins",   10'h20C, 8'h3F, 0, 0, 0, 0, 16'h0);
    irq_req = 1; irq_idx = 4'd1; stk_op = 2'b01;
    step("R10 irq with call", 10'h20C, 8'h3F, 1, 0, 0, 0, 16'h0);
    irq_req = 1; irq_idx = 4'd1;
    step("R10 held irq",     10'h208, 8'h3F, 1, 0, 1, 1, 16'h0106);
    step("R5 after take",    10'h204, 8'h3E, 0, 0, 0, 0, 16'h0);
    @(posedge clk);
    @(negedge clk);
    #1;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule